// File: doc/BRIEF.md
# Flash Self-Programming Command Controller

This block lets the processor rewrite its own program flash while it runs. Software reaches it through four byte-wide registers: the high and low halves of a 16-bit flash address, a data byte and a control register. An operation starts only when the start bit is written. At that moment the controller latches the address, the data and the operation code. It then issues a single command strobe to the flash array and holds the processor stalled until the operation has had its full duration.

Two guards stand between software and the array. The first is a write-unlock key: three bytes written to the data register in a fixed order. The second is a system-level enable. A reserved boot region at the top of the address space, sized in 512-byte blocks, is shielded from byte program and page erase. Such an operation still stalls for its normal time but sends nothing to the flash. A chip-wide protect state forces code reads to zero, and a chip erase clears that state again. Operation durations are parameters counted in clock cycles.

Top module: `flash_selfprog_ctrl`

## Requirements
- R1: After reset the address-high, address-low, data and control registers all read 00h, `cpu_stall` is 0 and `code_rdata_out` equals `code_rdata_in`.
- R2: `reg_addr` selects the register: 0 is address-high, 1 is address-low, 2 is data, 3 is control. Control reads as {start, 5'b0, function[1:0]}, and a write to control stores bits 1:0 as the function.
- R3: Writing control with bit 7 set starts an operation only if the three most recent data-register writes were 55h, AAh, 55h, in that order. A data write that breaks the order restarts matching; a 55h counts as a new first byte. A successful start uses up the key, so the next start needs a fresh key.
- R4: When the third key byte is written, the data register returns to the value it held before the first key byte of that sequence.
- R5: While `isp_enable` is 0, a start request is ignored: there is no stall, no strobe and the key stays armed.
- R6: Once started, `cpu_stall` and the start bit stay high for exactly the duration parameter of the selected function. If `flash_busy` is still high when that count ends, they stay high until the first cycle in which `flash_busy` is low.
- R7: A started, unguarded operation raises `flash_cmd_strobe` for one cycle, in the first stall cycle. During that cycle `flash_cmd_op` carries the function (00 byte program, 01 chip protect, 10 page erase, 11 chip erase) and `flash_cmd_data` carries the data register. For byte program and chip protect, `flash_cmd_addr` carries {address-high, address-low}.
- R8: For page erase, `flash_cmd_addr` is the given address with its low 9 bits cleared.
- R9: With `boot_blocks` = N (values above 8 treated as 8), a byte program or page erase whose address is at or above 65536 − 512·N sends no strobe but still stalls for its full duration. N = 0 reserves nothing.
- R10: For chip erase, `flash_cmd_addr` carries the highest address outside the reserved region: 65535 − 512·N, which is FFFFh when N = 0.
- R11: After a chip protect completes, `code_rdata_out` reads 00h. After a chip erase completes, it again follows `code_rdata_in`.
- R12: Register writes are ignored while the start bit is set, including a write in the cycle where the start bit clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| isp_enable | input | 1 | System-level enable for all flash operations |
| boot_blocks | input | BLK_W | Reserved boot region size in 512-byte blocks |
| flash_cmd_op | output | 2 | Latched operation code |
| flash_cmd_addr | output | 16 | Latched command address |
| flash_cmd_data | output | 8 | Latched program data |
| flash_cmd_strobe | output | 1 | One-cycle command issue pulse |
| flash_busy | input | 1 | Array still working; extends the stall |
| cpu_stall | output | 1 | Holds the processor while an operation runs |
| code_rdata_in | input | 8 | Raw program read data from the array |
| code_rdata_out | output | 8 | Program read data after protection |

## Verification
The end of an operation and a new register write can land on the same clock edge. The edge that clears the start bit must still drop any write presented with it. The bench provokes this by holding a write to the address-high register during the last stall cycle of an operation. It then reads the register back after the stall ends and expects the old value. A second overlap is the key completing and a start being requested back to back. The bench judges this by whether the stall length matches the function's duration, and by whether the start that follows, with no new key, is refused.

// File: rtl/fsp_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, register indices, key bytes and state encodings
// for the flash self-programming controller. Assumes byte-wide registers and
// a 16-bit flash address built from two bytes.
package fsp_pkg;
    localparam int FSP_BYTE_W = 8;
    localparam int FSP_ADDR_W = 2 * FSP_BYTE_W;

    localparam logic [1:0] REG_ADDR_HI = 2'd0;
    localparam logic [1:0] REG_ADDR_LO = 2'd1;
    localparam logic [1:0] REG_DATA    = 2'd2;
    localparam logic [1:0] REG_CTRL    = 2'd3;

    localparam logic [FSP_BYTE_W-1:0] KEY_FIRST  = 8'h55;
    localparam logic [FSP_BYTE_W-1:0] KEY_SECOND = 8'hAA;

    typedef enum logic [1:0] {
        OP_PROG    = 2'b00,
        OP_PROTECT = 2'b01,
        OP_PAGE    = 2'b10,
        OP_CHIP    = 2'b11
    } fsp_op_e;

    typedef enum logic [1:0] {
        K_IDLE  = 2'd0,
        K_ONE   = 2'd1,
        K_TWO   = 2'd2,
        K_ARMED = 2'd3
    } fsp_key_e;
endpackage

// File: rtl/fsp_key_unlock.sv
`timescale 1ns/1ps
// Module: fsp_key_unlock
// Tracks the three-byte write-unlock key written to the data register.
// Assumes data_wr pulses once per accepted data-register write and that
// consume never coincides with data_wr (they target different registers).
// key_begin marks a write that opens a new sequence from idle or armed, so the
// owner can save its data value; key_done marks the completing third byte.
module fsp_key_unlock
    import fsp_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  data_wr,
    input  logic [FSP_BYTE_W-1:0] wdata,
    input  logic                  consume,
    output logic                  armed,
    output logic                  key_begin,
    output logic                  key_done
);
    fsp_key_e st_q, st_d;

    // Next-state decode of the key sequence.
    always_comb begin
        st_d = st_q;
        if (consume) begin
            st_d = K_IDLE;
        end else if (data_wr) begin
            unique case (st_q)
                K_ONE:   st_d = (wdata == KEY_SECOND) ? K_TWO :
                                (wdata == KEY_FIRST)  ? K_ONE : K_IDLE;
                K_TWO:   st_d = (wdata == KEY_FIRST)  ? K_ARMED : K_IDLE;
                default: st_d = (wdata == KEY_FIRST)  ? K_ONE : K_IDLE;
            endcase
        end
    end

    // Key state register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= K_IDLE;
        else        st_q <= st_d;
    end

    // Status outputs for the register owner.
    always_comb begin
        armed     = (st_q == K_ARMED);
        key_begin = data_wr && (wdata == KEY_FIRST) &&
                    ((st_q == K_IDLE) || (st_q == K_ARMED));
        key_done  = data_wr && (wdata == KEY_FIRST) && (st_q == K_TWO);
    end
endmodule

// File: rtl/fsp_boot_guard.sv
`timescale 1ns/1ps
// Module: fsp_boot_guard
// Combinational check of an address against the reserved boot region at the
// top of the address space, plus the highest address a chip erase may touch.
// Assumes the region is a whole number of pages; counts above MAX_BLOCKS clamp.
module fsp_boot_guard
    import fsp_pkg::*;
#(
    parameter int PAGE_W     = 9,
    parameter int BLK_W      = 4,
    parameter int MAX_BLOCKS = 8
) (
    input  logic [BLK_W-1:0]      boot_blocks,
    input  logic [FSP_ADDR_W-1:0] addr,
    output logic                  in_region,
    output logic [FSP_ADDR_W-1:0] erase_limit
);
    localparam int PN_W  = FSP_ADDR_W - PAGE_W;
    localparam int PAGES = 1 << PN_W;

    logic [PN_W:0]         n_eff;
    logic [PN_W:0]         first_page;
    logic [FSP_ADDR_W:0]   limit_wide;

    // Clamp the block count and locate the first reserved page.
    always_comb begin
        n_eff = (boot_blocks > BLK_W'(MAX_BLOCKS)) ? (PN_W+1)'(MAX_BLOCKS)
                                                   : (PN_W+1)'(boot_blocks);
        first_page = (PN_W+1)'(PAGES) - n_eff;
    end

    // Region membership and chip-erase ceiling.
    always_comb begin
        in_region   = (n_eff != '0) &&
                      ({1'b0, addr[FSP_ADDR_W-1:PAGE_W]} >= first_page);
        limit_wide  = {first_page, {PAGE_W{1'b0}}} - (FSP_ADDR_W+1)'(1);
        erase_limit = limit_wide[FSP_ADDR_W-1:0];
    end
endmodule

// File: rtl/fsp_op_sequencer.sv
`timescale 1ns/1ps
// Module: fsp_op_sequencer
// Runs one flash operation: raises active on go, pulses strobe in the first
// active cycle unless the operation is guarded, counts the function's
// duration and then waits for flash_busy low. Assumes go only while idle and
// every duration parameter at least 1.
module fsp_op_sequencer
    import fsp_pkg::*;
#(
    parameter int DUR_PROG    = 8,
    parameter int DUR_PROTECT = 16,
    parameter int DUR_PAGE    = 40,
    parameter int DUR_CHIP    = 200
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    go,
    input  fsp_op_e op,
    input  logic    guard_block,
    input  logic    flash_busy,
    output logic    active,
    output logic    strobe,
    output logic    done
);
    localparam int CNT_W = $clog2(DUR_CHIP + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;

    // Duration reload for the requested function.
    always_comb begin
        unique case (op)
            OP_PROG:    load_val = CNT_W'(DUR_PROG - 1);
            OP_PROTECT: load_val = CNT_W'(DUR_PROTECT - 1);
            OP_PAGE:    load_val = CNT_W'(DUR_PAGE - 1);
            default:    load_val = CNT_W'(DUR_CHIP - 1);
        endcase
    end

    // Completion when the count is spent and the array is idle.
    always_comb done = active && (cnt_q == '0) && !flash_busy;

    // Activity flag, duration counter and command strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt_q  <= '0;
            strobe <= 1'b0;
        end else begin
            strobe <= go && !guard_block;
            if (go) begin
                active <= 1'b1;
                cnt_q  <= load_val;
            end else if (active) begin
                if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
                else if (!flash_busy) active <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/flash_selfprog_ctrl.sv
`timescale 1ns/1ps
// Module: flash_selfprog_ctrl (top)
// Register-mapped controller that programs, erases and protects the program
// flash on behalf of the processor. Owns the four software registers, the
// latched command and the read-protect state; delegates key tracking, boot
// region checks and operation timing to submodules. Assumes the processor
// issues no useful register writes while cpu_stall is high.
module flash_selfprog_ctrl
    import fsp_pkg::*;
#(
    parameter int PAGE_W      = 9,
    parameter int BLK_W       = 4,
    parameter int MAX_BLOCKS  = 8,
    parameter int DUR_PROG    = 8,
    parameter int DUR_PROTECT = 16,
    parameter int DUR_PAGE    = 40,
    parameter int DUR_CHIP    = 200
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr_en,
    input  logic [1:0]            reg_addr,
    input  logic [FSP_BYTE_W-1:0] reg_wdata,
    output logic [FSP_BYTE_W-1:0] reg_rdata,
    input  logic                  isp_enable,
    input  logic [BLK_W-1:0]      boot_blocks,
    output logic [1:0]            flash_cmd_op,
    output logic [FSP_ADDR_W-1:0] flash_cmd_addr,
    output logic [FSP_BYTE_W-1:0] flash_cmd_data,
    output logic                  flash_cmd_strobe,
    input  logic                  flash_busy,
    output logic                  cpu_stall,
    input  logic [FSP_BYTE_W-1:0] code_rdata_in,
    output logic [FSP_BYTE_W-1:0] code_rdata_out
);
    localparam int PAGE_LOW = PAGE_W;

    logic [FSP_BYTE_W-1:0] addr_hi_q, addr_lo_q, data_q, pre_key_q;
    logic [1:0]            func_q;
    logic                  prot_q;
    fsp_op_e               cmd_op_q;
    logic [FSP_ADDR_W-1:0] cmd_addr_q;
    logic [FSP_BYTE_W-1:0] cmd_data_q;

    logic                  active, strobe, done;
    logic                  accept, data_wr, ctrl_wr, go;
    logic                  armed, key_begin, key_done;
    logic                  in_region, guard_block;
    logic [FSP_ADDR_W-1:0] erase_limit, cur_addr, page_base;
    fsp_op_e               req_op;

    // Write qualification: nothing is accepted while an operation runs.
    always_comb begin
        accept   = reg_wr_en && !active;
        data_wr  = accept && (reg_addr == REG_DATA);
        ctrl_wr  = accept && (reg_addr == REG_CTRL);
        req_op   = fsp_op_e'(reg_wdata[1:0]);
        go       = ctrl_wr && reg_wdata[FSP_BYTE_W-1] && armed && isp_enable;
        cur_addr = {addr_hi_q, addr_lo_q};
        page_base = {cur_addr[FSP_ADDR_W-1:PAGE_LOW], {PAGE_LOW{1'b0}}};
        guard_block = ((req_op == OP_PROG) || (req_op == OP_PAGE)) && in_region;
    end

    fsp_key_unlock u_key (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_wr   (data_wr),
        .wdata     (reg_wdata),
        .consume   (go),
        .armed     (armed),
        .key_begin (key_begin),
        .key_done  (key_done)
    );

    fsp_boot_guard #(
        .PAGE_W     (PAGE_W),
        .BLK_W      (BLK_W),
        .MAX_BLOCKS (MAX_BLOCKS)
    ) u_guard (
        .boot_blocks (boot_blocks),
        .addr        (cur_addr),
        .in_region   (in_region),
        .erase_limit (erase_limit)
    );

    fsp_op_sequencer #(
        .DUR_PROG    (DUR_PROG),
        .DUR_PROTECT (DUR_PROTECT),
        .DUR_PAGE    (DUR_PAGE),
        .DUR_CHIP    (DUR_CHIP)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .go          (go),
        .op          (req_op),
        .guard_block (guard_block),
        .flash_busy  (flash_busy),
        .active      (active),
        .strobe      (strobe),
        .done        (done)
    );

    // Software registers, with key-byte restore of the data register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_hi_q <= '0;
            addr_lo_q <= '0;
            data_q    <= '0;
            pre_key_q <= '0;
            func_q    <= '0;
        end else if (accept) begin
            unique case (reg_addr)
                REG_ADDR_HI: addr_hi_q <= reg_wdata;
                REG_ADDR_LO: addr_lo_q <= reg_wdata;
                REG_DATA: begin
                    if (key_begin) pre_key_q <= data_q;
                    data_q <= key_done ? pre_key_q : reg_wdata;
                end
                default: func_q <= reg_wdata[1:0];
            endcase
        end
    end

    // Command latch taken at the start of an operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_op_q   <= OP_PROG;
            cmd_addr_q <= '0;
            cmd_data_q <= '0;
        end else if (go) begin
            cmd_op_q   <= req_op;
            cmd_data_q <= data_q;
            unique case (req_op)
                OP_PAGE: cmd_addr_q <= page_base;
                OP_CHIP: cmd_addr_q <= erase_limit;
                default: cmd_addr_q <= cur_addr;
            endcase
        end
    end

    // Read-protect state, updated when protect or chip erase completes.
    always_ff @(posedge clk) begin
        if (!rst_n) prot_q <= 1'b0;
        else if (done && (cmd_op_q == OP_PROTECT)) prot_q <= 1'b1;
        else if (done && (cmd_op_q == OP_CHIP))    prot_q <= 1'b0;
    end

    // Register read mux.
    always_comb begin
        unique case (reg_addr)
            REG_ADDR_HI: reg_rdata = addr_hi_q;
            REG_ADDR_LO: reg_rdata = addr_lo_q;
            REG_DATA:    reg_rdata = data_q;
            default:     reg_rdata = {active, {(FSP_BYTE_W-3){1'b0}}, func_q};
        endcase
    end

    // Port outputs.
    always_comb begin
        flash_cmd_op     = cmd_op_q;
        flash_cmd_addr   = cmd_addr_q;
        flash_cmd_data   = cmd_data_q;
        flash_cmd_strobe = strobe;
        cpu_stall        = active;
        code_rdata_out   = prot_q ? '0 : code_rdata_in;
    end
endmodule

// File: rtl/fsp_checker.sv
`timescale 1ns/1ps
// Module: fsp_checker
// Temporal properties of the flash self-programming controller, bound to the
// top. Assumes the register indices and key bytes of fsp_pkg.
module fsp_checker
    import fsp_pkg::*;
#(
    parameter int PAGE_W     = 9,
    parameter int BLK_W      = 4,
    parameter int MAX_BLOCKS = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  reg_wr_en,
    input logic [1:0]            reg_addr,
    input logic [FSP_BYTE_W-1:0] reg_wdata,
    input logic                  isp_enable,
    input logic [BLK_W-1:0]      boot_blocks,
    input logic                  cpu_stall,
    input logic                  flash_cmd_strobe,
    input logic [1:0]            flash_cmd_op,
    input logic [FSP_ADDR_W-1:0] flash_cmd_addr,
    input logic [FSP_BYTE_W-1:0] addr_hi_q,
    input logic [FSP_BYTE_W-1:0] addr_lo_q,
    input logic [FSP_BYTE_W-1:0] data_q
);
    logic [BLK_W-1:0]    blocks_prev;
    logic [FSP_ADDR_W:0] region_start;

    // Boot-region size seen at the edge that launched the current command.
    always_ff @(posedge clk) begin
        if (!rst_n) blocks_prev <= '0;
        else        blocks_prev <= boot_blocks;
    end

    // Lowest reserved address from the launching block count.
    always_comb begin
        if (blocks_prev > BLK_W'(MAX_BLOCKS))
            region_start = (FSP_ADDR_W+1)'(1 << FSP_ADDR_W) -
                           (FSP_ADDR_W+1)'(MAX_BLOCKS << PAGE_W);
        else
            region_start = (FSP_ADDR_W+1)'(1 << FSP_ADDR_W) -
                           ((FSP_ADDR_W+1)'(blocks_prev) << PAGE_W);
    end

    AST_STALL_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_stall) |-> $past(reg_wr_en && (reg_addr == REG_CTRL) &&
                                   reg_wdata[FSP_BYTE_W-1] && isp_enable)); // R3

    AST_STROBE_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        flash_cmd_strobe |-> cpu_stall && $rose(cpu_stall)); // R7

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        flash_cmd_strobe |=> !flash_cmd_strobe); // R7

    AST_PAGE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_cmd_strobe && (flash_cmd_op == OP_PAGE)) |->
            (flash_cmd_addr[PAGE_W-1:0] == '0)); // R8

    AST_BOOT_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_cmd_strobe && ((flash_cmd_op == OP_PROG) || (flash_cmd_op == OP_PAGE))) |->
            ({1'b0, flash_cmd_addr} < region_start)); // R9

    AST_REGS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cpu_stall) |-> ($stable(addr_hi_q) && $stable(addr_lo_q) && $stable(data_q))); // R12
endmodule

bind flash_selfprog_ctrl fsp_checker #(
    .PAGE_W     (PAGE_W),
    .BLK_W      (BLK_W),
    .MAX_BLOCKS (MAX_BLOCKS)
) i_fsp_checker (
    .clk              (clk),
    .rst_n            (rst_n),
    .reg_wr_en        (reg_wr_en),
    .reg_addr         (reg_addr),
    .reg_wdata        (reg_wdata),
    .isp_enable       (isp_enable),
    .boot_blocks      (boot_blocks),
    .cpu_stall        (cpu_stall),
    .flash_cmd_strobe (flash_cmd_strobe),
    .flash_cmd_op     (flash_cmd_op),
    .flash_cmd_addr   (flash_cmd_addr),
    .addr_hi_q        (addr_hi_q),
    .addr_lo_q        (addr_lo_q),
    .data_q           (data_q)
);

// File: tb/test_flash_selfprog_ctrl.sv
`timescale 1ns/1ps
module test_flash_selfprog_ctrl;
    localparam int DP = 8, DR = 16, DG = 40, DC = 200;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       isp_enable = 1'b0;
    logic [3:0] boot_blocks = 4'd0;
    logic [1:0] flash_cmd_op;
    logic [15:0] flash_cmd_addr;
    logic [7:0] flash_cmd_data;
    logic       flash_cmd_strobe;
    logic       flash_busy = 1'b0;
    logic       cpu_stall;
    logic [7:0] code_rdata_in = 8'h00;
    logic [7:0] code_rdata_out;

    int checks = 0, failures = 0;
    int strobe_cnt = 0;
    logic [1:0]  cap_op;
    logic [15:0] cap_addr;
    logic [7:0]  cap_data;

    // Reference model state.
    logic [7:0] m_hi = 0, m_lo = 0, m_data = 0, m_pre = 0;
    logic [1:0] m_func = 0;
    int         m_key = 0;
    bit         m_prot = 0;

    always #2.5 clk = ~clk;

    flash_selfprog_ctrl #(.DUR_PROG(DP), .DUR_PROTECT(DR), .DUR_PAGE(DG), .DUR_CHIP(DC))
    i_flash_selfprog_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .isp_enable(isp_enable),
        .boot_blocks(boot_blocks), .flash_cmd_op(flash_cmd_op),
        .flash_cmd_addr(flash_cmd_addr), .flash_cmd_data(flash_cmd_data),
        .flash_cmd_strobe(flash_cmd_strobe), .flash_busy(flash_busy),
        .cpu_stall(cpu_stall), .code_rdata_in(code_rdata_in),
        .code_rdata_out(code_rdata_out)
    );

    always @(negedge clk) begin
        if (rst_n && flash_cmd_strobe) begin
            strobe_cnt++;
            cap_op = flash_cmd_op; cap_addr = flash_cmd_addr; cap_data = flash_cmd_data;
        end
    end

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int dur_of(logic [1:0] f);
        case (f)
            2'b00: return DP;
            2'b01: return DR;
            2'b10: return DG;
            default: return DC;
        endcase
    endfunction

    function automatic int region_lo(int n);
        int ne = (n > 8) ? 8 : n;
        return 65536 - ne * 512;
    endfunction

    function automatic int exp_addr(logic [1:0] f, int a, int n);
        if (f == 2'b10) return a & 16'hFE00;
        if (f == 2'b11) return region_lo(n) - 1;
        return a;
    endfunction

    task automatic wr(logic [1:0] a, logic [7:0] v);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    // Register write with model update (only used while idle).
    task automatic put(logic [1:0] a, logic [7:0] v);
        int nk;
        case (a)
            2'd0: m_hi = v;
            2'd1: m_lo = v;
            2'd2: begin
                case (m_key)
                    1: nk = (v == 8'hAA) ? 2 : ((v == 8'h55) ? 1 : 0);
                    2: nk = (v == 8'h55) ? 3 : 0;
                    default: nk = (v == 8'h55) ? 1 : 0;
                endcase
                if (v == 8'h55 && (m_key == 0 || m_key == 3)) m_pre = m_data;
                if (m_key == 2 && v == 8'h55) m_data = m_pre; else m_data = v;
                m_key = nk;
            end
            default: m_func = v[1:0];
        endcase
        wr(a, v);
    endtask

    task automatic send_key();
        put(2, 8'h55); put(2, 8'hAA); put(2, 8'h55);
    endtask

    task automatic rd_chk(logic [1:0] a, logic [7:0] e, string tag);
        reg_addr = a; #1;
        chk(reg_rdata == e, tag, reg_rdata, e);
    endtask

    task automatic check_regs(string tag);
        rd_chk(0, m_hi, tag); rd_chk(1, m_lo, tag);
        rd_chk(2, m_data, tag); rd_chk(3, {6'b0, m_func}, tag);
    endtask

    // Start request with full outcome check. late: write during last stall cycle.
    task automatic start_op(logic [1:0] f, bit late, int busy_ext);
        bit go, blocked;
        int a, n, d, en;
        go = (m_key == 3) && isp_enable;
        a = {m_hi, m_lo};
        blocked = (f == 2'b00 || f == 2'b10) && (a >= region_lo(boot_blocks)) && (boot_blocks != 0);
        d = dur_of(f);
        strobe_cnt = 0;
        if (busy_ext != 0) flash_busy = 1'b1;
        wr(3, {1'b1, 5'b0, f});
        m_func = f;
        n = 0;
        while (cpu_stall) begin
            n++;
            if (late && n == d) begin
                reg_wr_en = 1'b1; reg_addr = 0; reg_wdata = ~m_hi;
            end
            if (busy_ext != 0 && n == busy_ext) flash_busy = 1'b0;
            @(negedge clk);
        end
        reg_wr_en = 1'b0;
        en = go ? ((busy_ext != 0) ? busy_ext : d) : 0;
        chk(n == en, "R6 stall length", n, en);
        if (go) begin
            m_key = 0;
            chk(strobe_cnt == (blocked ? 0 : 1), blocked ? "R9 guard strobe" : "R7 strobe count",
                strobe_cnt, blocked ? 0 : 1);
            if (!blocked) begin
                chk(cap_op == f, "R7 op", cap_op, f);
                chk(cap_data == m_data, "R7 data", cap_data, m_data);
                chk(cap_addr == exp_addr(f, a, boot_blocks),
                    (f == 2'b10) ? "R8 page addr" : (f == 2'b11) ? "R10 erase limit" : "R7 addr",
                    cap_addr, exp_addr(f, a, boot_blocks));
            end
            if (f == 2'b01) m_prot = 1;
            if (f == 2'b11) m_prot = 0;
        end else begin
            chk(strobe_cnt == 0, isp_enable ? "R3 no key" : "R5 disabled", strobe_cnt, 0);
        end
        code_rdata_in = 8'($urandom_range(1, 255)); #1;
        chk(code_rdata_out == (m_prot ? 8'h00 : code_rdata_in), "R11 read filter",
            code_rdata_out, m_prot ? 8'h00 : code_rdata_in);
        if (late) rd_chk(0, m_hi, "R12 late write dropped");
        rd_chk(3, {6'b0, m_func}, "R2 ctrl readback");
    endtask

    task automatic set_addr(int a);
        put(0, 8'(a >> 8)); put(1, 8'(a));
    endtask

    initial begin
        void'($urandom(32'd7031));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd_chk(0, 8'h00, "R1 addr hi"); rd_chk(1, 8'h00, "R1 addr lo");
        rd_chk(2, 8'h00, "R1 data");    rd_chk(3, 8'h00, "R1 ctrl");
        chk(cpu_stall == 1'b0, "R1 stall", cpu_stall, 0);
        code_rdata_in = 8'h3C; #1;
        chk(code_rdata_out == 8'h3C, "R1 read passthrough", code_rdata_out, 8'h3C);
        // R2 register map
        put(0, 8'h12); put(1, 8'h34); put(2, 8'h22); put(3, 8'h03);
        check_regs("R2 map");
        isp_enable = 1'b1;
        // R3 start without key
        start_op(2'b00, 0, 0);
        // R4 key restores data
        send_key();
        rd_chk(2, 8'h22, "R4 data restored");
        // R5 disabled then enabled with same key
        isp_enable = 1'b0; start_op(2'b00, 0, 0);
        isp_enable = 1'b1; start_op(2'b00, 0, 0);
        // R3 key consumed
        start_op(2'b00, 0, 0);
        // R3 broken order then restart on repeated first byte
        put(2, 8'h55); put(2, 8'h11); put(2, 8'hAA); put(2, 8'h55);
        start_op(2'b00, 0, 0);
        put(2, 8'h55); put(2, 8'hAA); put(2, 8'h55);
        start_op(2'b00, 0, 0);
        put(2, 8'h55); put(2, 8'h55); put(2, 8'hAA); put(2, 8'h55);
        start_op(2'b00, 0, 0);
        // R8 page erase alignment
        set_addr(16'h1305); send_key(); start_op(2'b10, 0, 0);
        // R9 boot region guard
        boot_blocks = 4'd2;
        set_addr(16'hFC00); send_key(); start_op(2'b00, 0, 0);
        set_addr(16'hFBFF); send_key(); start_op(2'b00, 0, 0);
        set_addr(16'hFD10); send_key(); start_op(2'b10, 0, 0);
        boot_blocks = 4'd12;
        set_addr(16'hF000); send_key(); start_op(2'b00, 0, 0);
        set_addr(16'hEFFF); send_key(); start_op(2'b00, 0, 0);
        boot_blocks = 4'd0;
        set_addr(16'hFFFF); send_key(); start_op(2'b00, 0, 0);
        // R10 chip erase limit, R11 protect
        send_key(); start_op(2'b01, 0, 0);
        boot_blocks = 4'd3; send_key(); start_op(2'b11, 0, 0);
        boot_blocks = 4'd0; send_key(); start_op(2'b11, 0, 0);
        // R6 busy extension
        send_key(); start_op(2'b00, 0, DP + 5);
        // R12 write in the clearing cycle
        send_key(); start_op(2'b10, 1, 0);
        check_regs("R12 regs after op");
        // Random phase
        for (int it = 0; it < 150; it++) begin
            int r;
            r = $urandom_range(0, 9);
            case (r)
                0: put(0, ($urandom_range(0, 2) == 0) ? 8'($urandom_range(8'hF0, 8'hFF))
                                                      : 8'($urandom));
                1: put(1, 8'($urandom));
                2: begin
                    int s = $urandom_range(0, 2);
                    put(2, (s == 0) ? 8'h55 : (s == 1) ? 8'hAA : 8'($urandom));
                end
                3, 4, 5: begin
                    send_key();
                    start_op(2'($urandom), 0, 0);
                end
                6: start_op(2'($urandom), 0, 0);
                7: isp_enable = ($urandom_range(0, 4) != 0);
                8: boot_blocks = 4'($urandom_range(0, 10));
                default: check_regs("R2 random readback");
            endcase
        end
        check_regs("R2 final readback");
        summary();
    end
endmodule